// File: doc/BRIEF.md
# Pulse Program Instruction Sequencer

This block runs a short timing program held in an on-chip instruction store. Every instruction carries a flag word, an opcode, a data field and a delay count. While an instruction executes, the flag word sits unchanged on the flag output. When the instruction's time is up, the sequencer moves on to the next instruction that the control flow selects.

Control flow covers counted loops that can nest, subroutine call and return, an unconditional jump, a long delay that multiplies the delay count by the data field, a pause that waits for an external trigger, and a stop. A host loads the program through a simple write port while the sequencer is idle. It then pulses `start_i` and watches `running_o`, `done_o` and `err_o`.

The loop counters and the return addresses are kept in two separate stacks, each a fixed number of entries deep. Pushing onto a full stack or popping an empty one is a program fault. A fault halts the sequencer and sets the error output.

Top module: `pulse_seq`

## Requirements
- R1: An instruction word is `{flags[39:32], opcode[31:28], data[27:16], delay[15:0]}`. Opcodes are CONTINUE=0, STOP=1, LOOP=2, END_LOOP=3, JSR=4, RTS=5, BRANCH=6, LONG_DELAY=7 and WAIT=8. A CONTINUE holds its flag word on `flags_o` for exactly max(delay,5) cycles and then moves to the next address. The first instruction's flags appear on the second rising edge after the edge that samples `start_i`.
- R2: A delay count below 5 is executed as 5 cycles.
- R3: LOOP pushes its data field as an iteration count and moves to the next address. END_LOOP handles the top count as follows. If the count is above 1, it decrements the count and jumps to the address in its data field. Otherwise it pops the count and falls through, so the body runs the given number of times.
- R4: JSR saves the address after itself and jumps to the address in its data field. RTS ignores its data field and resumes at the saved address.
- R5: BRANCH continues at the address in its data field. The instructions it skips never drive the outputs.
- R6: LONG_DELAY with a data field of 2 or more lasts max(delay,5) times data cycles. With a data field below 2, it lasts max(delay,5) cycles and sets `err_o`.
- R7: WAIT keeps its flags and waits for as long as `trig_i` is low; its data field is ignored. Let T be the first rising edge that samples `trig_i` high during the wait. The next instruction's flags appear max(delay,5)+6 cycles after T.
- R8: STOP drives `flags_o` to zero, drops `running_o` and raises `done_o`.
- R9: Each stack holds 8 entries. A ninth push, or END_LOOP or RTS on an empty stack, drives `flags_o` to zero, drops `running_o`, sets `err_o` and leaves `done_o` low. The faulting instruction's flags never appear.
- R10: After reset, `flags_o`, `running_o`, `done_o` and `err_o` are all zero. A start from idle raises `running_o` and clears `done_o` and `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin execution at address 0 (acted on while idle) |
| trig_i | input | 1 | Trigger that releases a WAIT instruction |
| wr_en_i | input | 1 | Instruction store write enable |
| wr_addr_i | input | ADDR_W | Instruction store write address |
| wr_data_i | input | 40 | Instruction word to store |
| flags_o | output | 8 | Flag word of the executing instruction |
| running_o | output | 1 | Program executing |
| done_o | output | 1 | Program ended on STOP |
| err_o | output | 1 | Sticky error (stack fault or short long delay) |

## Verification
The hardest states to reach are the edges of the loop stack. One case is a loop counter decremented back to the same body while the call stack holds a return address. The other is a ninth nested push, which only a long run of consecutive LOOP words can produce.

The stimulus loads three programs through the write port:
- A mixed program with a three-pass loop, a subroutine, a jump over a decoy word, both long-delay cases and a trigger wait released a known number of cycles into it.
- A return with nothing on the call stack.
- Nine nested LOOPs.

A scoreboard compares each flag segment's value and length against the queued prediction.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int FLAG_W  = 8;
  localparam int OPC_W   = 4;
  localparam int DATA_W  = 12;
  localparam int DLY_W   = 16;
  localparam int INSTR_W = FLAG_W + OPC_W + DATA_W + DLY_W;

  typedef enum logic [OPC_W-1:0] {
    OP_CONT  = 4'd0,
    OP_STOP  = 4'd1,
    OP_LOOP  = 4'd2,
    OP_ENDL  = 4'd3,
    OP_CALL  = 4'd4,
    OP_RET   = 4'd5,
    OP_JUMP  = 4'd6,
    OP_LONG  = 4'd7,
    OP_WAIT  = 4'd8
  } op_e;

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    op_e               op;
    logic [DATA_W-1:0] data;
    logic [DLY_W-1:0]  dly;
  } instr_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_ISSUE,
    S_EXEC,
    S_WAIT
  } seq_st_e;
endpackage

// File: rtl/pps_imem.sv
module pps_imem #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 40
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pps_stack.sv
module pps_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic         pop,
  input  logic         upd,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  localparam int IX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SP_W = $clog2(DEPTH + 1);

  logic [W-1:0]    ent [DEPTH];
  logic [SP_W-1:0] sp;
  logic [IX_W-1:0] top_ix;
  logic [IX_W-1:0] wr_ix;

  assign top_ix = IX_W'(sp - 1'b1);
  assign wr_ix  = IX_W'(sp);
  assign empty  = (sp == '0);
  assign full   = (sp == SP_W'(DEPTH));
  assign top    = empty ? '0 : ent[top_ix];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sp <= '0;
    end else if (push && !full) begin
      sp <= sp + 1'b1;
    end else if (pop && !empty) begin
      sp <= sp - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && !clr) begin
      if (push && !full)        ent[wr_ix]  <= din;
      else if (upd && !empty)   ent[top_ix] <= din;
    end
  end

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst) (full && !clr) |-> !push); // R9
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst) (empty && !clr) |-> !(pop || upd)); // R9
endmodule

// File: rtl/pulse_seq.sv
module pulse_seq
  import pps_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int STACK_D    = 8,
  parameter int MIN_DLY    = 5,
  parameter int WAIT_EXTRA = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 trig_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [INSTR_W-1:0]   wr_data_i,
  output logic [FLAG_W-1:0]    flags_o,
  output logic                 running_o,
  output logic                 done_o,
  output logic                 err_o
);
  localparam int CNT_W = DLY_W + DATA_W;

  seq_st_e           st_q;
  logic [ADDR_W-1:0] pc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [INSTR_W-1:0] rd_word;
  instr_t            ins;

  pps_imem #(.ADDR_W(ADDR_W), .WORD_W(INSTR_W)) imem_i (
    .clk(clk), .we(wr_en_i), .waddr(wr_addr_i), .wdata(wr_data_i),
    .raddr(pc_q), .rdata(rd_word)
  );
  assign ins = rd_word;

  logic issue, launch;
  assign issue  = (st_q == S_ISSUE);
  assign launch = (st_q == S_IDLE) && start_i;

  // loop counter stack
  logic [DATA_W-1:0] ls_top, ls_din;
  logic ls_empty, ls_full, ls_push, ls_pop, ls_dec, ls_fault;
  logic is_loop, is_endl;
  assign is_loop  = issue && (ins.op == OP_LOOP);
  assign is_endl  = issue && (ins.op == OP_ENDL);
  assign ls_push  = is_loop && !ls_full;
  assign ls_dec   = is_endl && !ls_empty && (ls_top > DATA_W'(1));
  assign ls_pop   = is_endl && !ls_empty && (ls_top <= DATA_W'(1));
  assign ls_fault = (is_loop && ls_full) || (is_endl && ls_empty);
  assign ls_din   = ls_dec ? (ls_top - 1'b1) : ins.data;

  pps_stack #(.DEPTH(STACK_D), .W(DATA_W)) loop_stk_i (
    .clk(clk), .rst(rst), .clr(launch), .push(ls_push), .pop(ls_pop),
    .upd(ls_dec), .din(ls_din), .top(ls_top), .empty(ls_empty), .full(ls_full)
  );

  // return address stack
  logic [ADDR_W-1:0] cs_top, pc_inc;
  logic cs_empty, cs_full, cs_push, cs_pop, cs_fault;
  logic is_call, is_ret;
  assign pc_inc   = pc_q + 1'b1;
  assign is_call  = issue && (ins.op == OP_CALL);
  assign is_ret   = issue && (ins.op == OP_RET);
  assign cs_push  = is_call && !cs_full;
  assign cs_pop   = is_ret && !cs_empty;
  assign cs_fault = (is_call && cs_full) || (is_ret && cs_empty);

  pps_stack #(.DEPTH(STACK_D), .W(ADDR_W)) call_stk_i (
    .clk(clk), .rst(rst), .clr(launch), .push(cs_push), .pop(cs_pop),
    .upd(1'b0), .din(pc_inc), .top(cs_top), .empty(cs_empty), .full(cs_full)
  );

  // next address and duration
  logic [ADDR_W-1:0] tgt, pc_nxt;
  logic [DLY_W-1:0]  dly_eff;
  logic [CNT_W-1:0]  dur, wait_cnt;
  logic              long_ok, fault;

  assign tgt      = ins.data[ADDR_W-1:0];
  assign dly_eff  = (ins.dly < DLY_W'(MIN_DLY)) ? DLY_W'(MIN_DLY) : ins.dly;
  assign long_ok  = (ins.data >= DATA_W'(2));
  assign fault    = ls_fault || cs_fault;
  assign wait_cnt = CNT_W'(dly_eff) + CNT_W'(WAIT_EXTRA) - CNT_W'(2);

  always_comb begin
    pc_nxt = pc_inc;
    dur    = CNT_W'(dly_eff);
    case (ins.op)
      OP_ENDL: if (ls_dec) pc_nxt = tgt;
      OP_CALL: pc_nxt = tgt;
      OP_RET:  pc_nxt = cs_top;
      OP_JUMP: pc_nxt = tgt;
      OP_LONG: if (long_ok) dur = CNT_W'(dly_eff) * CNT_W'(ins.data);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      pc_q      <= '0;
      cnt_q     <= '0;
      flags_o   <= '0;
      running_o <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          pc_q      <= '0;
          running_o <= 1'b1;
          done_o    <= 1'b0;
          err_o     <= 1'b0;
          st_q      <= S_FETCH;
        end
        S_FETCH: st_q <= S_ISSUE;
        S_ISSUE: begin
          if (fault) begin
            flags_o   <= '0;
            running_o <= 1'b0;
            err_o     <= 1'b1;
            st_q      <= S_IDLE;
          end else if (ins.op == OP_STOP) begin
            flags_o   <= '0;
            running_o <= 1'b0;
            done_o    <= 1'b1;
            st_q      <= S_IDLE;
          end else begin
            flags_o <= ins.flags;
            pc_q    <= pc_nxt;
            if (ins.op == OP_LONG && !long_ok) err_o <= 1'b1;
            if (ins.op == OP_WAIT) begin
              cnt_q <= wait_cnt;
              st_q  <= S_WAIT;
            end else begin
              cnt_q <= dur - CNT_W'(2);
              st_q  <= S_EXEC;
            end
          end
        end
        S_EXEC: begin
          if (cnt_q == '0) st_q <= S_ISSUE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        S_WAIT: if (trig_i) st_q <= S_EXEC;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // dwell counter used only by the minimum-length check
  logic [7:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst || issue) gap_q <= '0;
    else if (gap_q != 8'hFF) gap_q <= gap_q + 1'b1;
  end

  AST_FLAGS_STABLE: assert property (@(posedge clk) disable iff (rst) (st_q != S_ISSUE) |=> $stable(flags_o)); // R1
  AST_MIN_DWELL: assert property (@(posedge clk) disable iff (rst) (issue && $past(st_q) != S_FETCH) |-> (gap_q >= 8'(MIN_DLY - 1))); // R2
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst) (st_q == S_WAIT && !trig_i) |=> (st_q == S_WAIT && $stable(flags_o))); // R7
  AST_STOP_ZERO: assert property (@(posedge clk) disable iff (rst) $rose(done_o) |-> (flags_o == '0 && !running_o)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done_o |-> !running_o); // R8
endmodule

// File: tb/pulse_seq_tb_top.sv
`timescale 1ns/1ps
module pulse_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        trig_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  wr_addr_i = '0;
  logic [39:0] wr_data_i = '0;
  logic [7:0]  flags_o;
  logic        running_o, done_o, err_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] exp_f[$];
  int         exp_n[$];
  string      exp_r[$];

  logic [7:0] prev_f = '0;
  int         seg_len = 0;

  always #2.5 clk = ~clk;

  pulse_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .trig_i(trig_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .flags_o(flags_o), .running_o(running_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wr(input int a, input logic [7:0] f, input logic [3:0] op,
                    input logic [11:0] d, input logic [15:0] dl);
    @(negedge clk);
    wr_en_i   = 1'b1;
    wr_addr_i = 6'(a);
    wr_data_i = {f, op, d, dl};
    @(negedge clk);
    wr_en_i   = 1'b0;
  endtask

  task automatic push_exp(input logic [7:0] f, input int n, input string r);
    exp_f.push_back(f);
    exp_n.push_back(n);
    exp_r.push_back(r);
  endtask

  // monitor: one scoreboard item per constant non-zero flag segment
  always @(negedge clk) begin
    if (!rst) begin
      if (flags_o !== prev_f) begin
        if (prev_f != 8'h00) begin
          if (exp_f.size() == 0) begin
            chk(1'b0, "R1 unexpected segment", int'(prev_f), 0);
          end else begin
            logic [7:0] ef;
            int en;
            string er;
            ef = exp_f.pop_front();
            en = exp_n.pop_front();
            er = exp_r.pop_front();
            chk(prev_f == ef, {er, " flags"}, int'(prev_f), int'(ef));
            chk(seg_len == en, {er, " length"}, seg_len, en);
          end
        end
        prev_f  = flags_o;
        seg_len = 1;
      end else begin
        seg_len++;
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!running_o) break;
    end
    @(negedge clk);
  endtask

  task automatic trig_after(input logic [7:0] f, input int k);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (flags_o == f) break;
    end
    repeat (k) @(negedge clk);
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(flags_o == 0, "R10 reset flags", int'(flags_o), 0);
    chk(running_o == 0, "R10 reset running", int'(running_o), 0);
    chk(done_o == 0, "R10 reset done", int'(done_o), 0);
    chk(err_o == 0, "R10 reset err", int'(err_o), 0);

    // program A
    wr(0,  8'h01, 4'd0, 12'd0,  16'd7);   // CONTINUE 7
    wr(1,  8'h02, 4'd0, 12'd0,  16'd2);   // R2: 2 -> 5
    wr(2,  8'h03, 4'd2, 12'd3,  16'd5);   // LOOP x3
    wr(3,  8'h04, 4'd0, 12'd0,  16'd6);
    wr(4,  8'h05, 4'd3, 12'd3,  16'd5);   // END_LOOP -> 3
    wr(5,  8'h06, 4'd4, 12'd20, 16'd5);   // JSR 20
    wr(6,  8'h09, 4'd6, 12'd10, 16'd5);   // BRANCH 10
    wr(7,  8'h0A, 4'd0, 12'd0,  16'd5);   // skipped
    wr(10, 8'h0B, 4'd7, 12'd4,  16'd6);   // LONG 6*4
    wr(11, 8'h0C, 4'd7, 12'd1,  16'd9);   // LONG data 1 -> 9, err
    wr(12, 8'h0D, 4'd8, 12'd99, 16'd5);   // WAIT
    wr(13, 8'h0E, 4'd1, 12'd0,  16'd5);   // STOP
    wr(20, 8'h07, 4'd0, 12'd0,  16'd8);
    wr(21, 8'h08, 4'd5, 12'd55, 16'd5);   // RTS

    push_exp(8'h01, 7, "R1");
    push_exp(8'h02, 5, "R2");
    push_exp(8'h03, 5, "R3");
    for (int i = 0; i < 3; i++) begin
      push_exp(8'h04, 6, "R3");
      push_exp(8'h05, 5, "R3");
    end
    push_exp(8'h06, 5, "R4");
    push_exp(8'h07, 8, "R4");
    push_exp(8'h08, 5, "R4");
    push_exp(8'h09, 5, "R5");
    push_exp(8'h0B, 24, "R6");
    push_exp(8'h0C, 9, "R6");
    push_exp(8'h0D, 7 + 1 + 5 + 6, "R7");   // k+1 to trigger edge, then 5+6

    pulse_start();
    chk(running_o == 1, "R10 running after start", int'(running_o), 1);
    chk(flags_o == 0, "R1 latency edge+1", int'(flags_o), 0);
    @(negedge clk);
    chk(flags_o == 0, "R1 latency edge+1", int'(flags_o), 0);
    @(negedge clk);
    chk(flags_o == 8'h01, "R1 latency edge+2", int'(flags_o), 1);
    fork
      wait_idle();
      trig_after(8'h0D, 7);
    join
    chk(exp_f.size() == 0, "R5 all segments seen", exp_f.size(), 0);
    chk(flags_o == 0, "R8 stop flags", int'(flags_o), 0);
    chk(done_o == 1, "R8 done", int'(done_o), 1);
    chk(running_o == 0, "R8 running", int'(running_o), 0);
    chk(err_o == 1, "R6 short long delay err", int'(err_o), 1);

    // program B: return with empty call stack
    wr(0, 8'h11, 4'd0, 12'd0, 16'd3);
    wr(1, 8'h12, 4'd5, 12'd0, 16'd5);
    push_exp(8'h11, 5, "R9");
    pulse_start();
    chk(err_o == 0, "R10 start clears err", int'(err_o), 0);
    chk(done_o == 0, "R10 start clears done", int'(done_o), 0);
    wait_idle();
    chk(exp_f.size() == 0, "R9 underflow segments", exp_f.size(), 0);
    chk(err_o == 1, "R9 underflow err", int'(err_o), 1);
    chk(done_o == 0, "R9 underflow done", int'(done_o), 0);
    chk(flags_o == 0, "R9 underflow flags", int'(flags_o), 0);

    // program C: nine nested loops
    for (int i = 0; i < 9; i++) wr(i, 8'(8'h20 + i), 4'd2, 12'd2, 16'd5);
    for (int i = 0; i < 8; i++) push_exp(8'(8'h20 + i), 5, "R9");
    pulse_start();
    wait_idle();
    chk(exp_f.size() == 0, "R9 overflow segments", exp_f.size(), 0);
    chk(err_o == 1, "R9 overflow err", int'(err_o), 1);
    chk(running_o == 0, "R9 overflow halt", int'(running_o), 0);
    chk(flags_o == 0, "R9 overflow flags", int'(flags_o), 0);

    repeat (3) @(negedge clk);
    report();
  end
endmodule